// File: doc/BRIEF.md
# Line Signal-Loss and Mark-Density Monitor

This block watches a recovered single-rail mark stream, one bit per line-clock enable, and reports two conditions. The first is a signal-loss alarm. It goes up when the stream carries no marks for a programmable span. It comes down only after a separate, programmable number of marks is counted inside a span of the same length, and that span is opened by a mark. The second is a mark-density violation flag. It is raised while the stream holds too long a run of zeros, or while too few ones sit in a sliding window of recent bits.

Both conditions are level status outputs. A one-clock interrupt strobe marks their changes: onsets only, or onsets and ends when the both-edges option is set. The detect span and the recovery mark count are 8-bit inputs. Typical programmed values are 0xC0 for the span and 0x18 for the count. The span in bit periods is the span value times sixteen, plus one.

Top module: `los_pd_monitor`

## Requirements
- R1: After reset, `los_o`, `pden_o` and `irq_o` are all low.
- R2: With the alarm low, `los_o` rises after the bit that completes a run of exactly `det_len*16+1` consecutive zero bits, and not one bit earlier.
- R3: A mark (`mark_in`=1 on an enabled bit) restarts the zero run, so interrupted runs never raise the alarm.
- R4: While the alarm is up and no mark has arrived since it rose, any number of zero bits leaves `los_o` high; recovery starts only on a mark.
- R5: The starting mark counts as the first mark. `los_o` falls on the bit at which the mark count reaches `rec_marks`, provided that bit lies within `det_len*16+1` bits counted from the starting mark (that mark being bit 1).
- R6: If that span ends before the count is reached, `los_o` stays high, the count is dropped, and a fresh span begins at the next mark.
- R7: `pden_o` is high from the 16th consecutive zero bit onward while the zero run continues, and a mark ends that cause.
- R8: Once 192 bits have arrived since reset, `pden_o` is also high whenever the latest 192 bits hold fewer than 23 ones.
- R9: With `irq_both`=0, `irq_o` pulses high for exactly one clock, one clock after either status output rises. Falls produce no pulse.
- R10: With `irq_both`=1, falls of either status output pulse `irq_o` as well. Changes of both outputs on the same bit give a single pulse.
- R11: Cycles with `bit_en` low change no state, whatever `mark_in` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies one line bit on this clock |
| mark_in | input | 1 | Line bit, 1 = mark |
| det_len | input | 8 | Detect span; span in bits = value*16+1 |
| rec_marks | input | 8 | Marks needed within one span to clear the alarm |
| irq_both | input | 1 | 1 = strobe on falls as well as rises |
| los_o | output | 1 | Signal-loss alarm |
| pden_o | output | 1 | Mark-density violation |
| irq_o | output | 1 | One-clock change strobe |

## Verification
Several zero runs are sent. Some stop one bit short of the span and some reach it exactly, which pins the detect threshold. One of them has idle cycles carrying a mark inside it, which separates a true mark from a disabled cycle. During recovery, marks are spaced so that they fall inside one span or straddle an expired one. This tells counting per span apart from counting over the whole alarm. For density, a 15-zero run is set against a 16-zero run. A bit pattern is also slid through the window so that its ones count goes 23, 22, 23, which shows the window really slides rather than counting in blocks. The strobe is counted over one set sequence with the both-edges option off and then on.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LS_OK    = 2'd0,
    LS_WAIT  = 2'd1,
    LS_RECOV = 2'd2
  } los_state_t;
endpackage

// File: rtl/lpm_los_detector.sv
module lpm_los_detector #(
  parameter int DW    = 8,
  parameter int SH    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          mark_in,
  input  logic [DW-1:0] det_len,
  input  logic [DW-1:0] rec_marks,
  output logic          los_o
);
  import lpm_pkg::*;

  localparam int CW = DW + SH + 1;

  los_state_t    st_q, st_n;
  logic [CW-1:0] zr_q, zr_n;
  logic [CW-1:0] wc_q, wc_n;
  logic [CW-1:0] mc_q, mc_n;
  logic          los_q, los_n;
  logic [CW-1:0] span;
  logic [CW-1:0] need;
  logic [CW-1:0] wc_inc, mc_inc, zr_inc;

  assign span   = {{(CW-DW-SH){1'b0}}, det_len, {SH{1'b0}}} + CW'(1);
  assign need   = {{(CW-DW){1'b0}}, rec_marks};
  assign zr_inc = zr_q + CW'(1);
  assign wc_inc = wc_q + CW'(1);
  assign mc_inc = mc_q + CW'(mark_in);

  always_comb begin
    st_n  = st_q;
    zr_n  = zr_q;
    wc_n  = wc_q;
    mc_n  = mc_q;
    los_n = los_q;
    if (bit_en) begin
      unique case (st_q)
        LS_OK: begin
          if (mark_in) begin
            zr_n = '0;
          end else if (zr_inc >= span) begin
            st_n  = LS_WAIT;
            los_n = 1'b1;
            zr_n  = '0;
          end else begin
            zr_n = zr_inc;
          end
        end
        LS_WAIT: begin
          if (mark_in) begin
            wc_n = CW'(1);
            mc_n = CW'(1);
            if (CW'(1) >= need) begin
              st_n  = LS_OK;
              los_n = 1'b0;
              zr_n  = '0;
            end else begin
              st_n = LS_RECOV;
            end
          end
        end
        LS_RECOV: begin
          if (mc_inc >= need) begin
            st_n  = LS_OK;
            los_n = 1'b0;
            zr_n  = '0;
          end else if (wc_inc >= span) begin
            st_n = LS_WAIT;
          end else begin
            wc_n = wc_inc;
            mc_n = mc_inc;
          end
        end
        default: begin
          st_n  = LS_OK;
          los_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LS_OK;
      zr_q  <= '0;
      wc_q  <= '0;
      mc_q  <= '0;
      los_q <= 1'b0;
    end else if (bit_en) begin
      st_q  <= st_n;
      zr_q  <= zr_n;
      wc_q  <= wc_n;
      mc_q  <= mc_n;
      los_q <= los_n;
    end
  end

  assign los_o = los_q;

  // R2: the alarm only rises on an enabled zero bit
  a_r2_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_q) |-> $past(bit_en && !mark_in));
  // R4: the alarm only clears on an enabled mark
  a_r4_fall_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_q) |-> $past(bit_en && mark_in));
  // R11: disabled cycles leave the alarm alone
  a_r11_los_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(los_q));
  // R5: alarm state and FSM state agree
  a_r5_state_match: assert property (@(posedge clk) disable iff (!rst_n)
    los_q == (st_q != LS_OK));
endmodule

// File: rtl/lpm_density_checker.sv
module lpm_density_checker #(
  parameter int ZMAX = 15,
  parameter int PD_N = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic mark_in,
  output logic pden_o
);
  localparam int WIN = 8 * (PD_N + 1);
  localparam int OW  = $clog2(WIN + 1);
  localparam int ZW  = $clog2(ZMAX + 2);

  logic [WIN-1:0] sr_q, sr_n;
  logic [OW-1:0]  ones_q, ones_n;
  logic [OW-1:0]  fill_q, fill_n;
  logic [ZW-1:0]  zr_q, zr_n;
  logic           pden_q, pden_n;
  logic           win_bad;

  always_comb begin
    sr_n   = {sr_q[WIN-2:0], mark_in};
    ones_n = ones_q + OW'(mark_in) - OW'(sr_q[WIN-1]);
    fill_n = (fill_q == OW'(WIN)) ? fill_q : fill_q + OW'(1);
    if (mark_in)                  zr_n = '0;
    else if (zr_q == ZW'(ZMAX+1)) zr_n = zr_q;
    else                          zr_n = zr_q + ZW'(1);
    win_bad = (fill_n == OW'(WIN)) && (ones_n < OW'(PD_N));
    pden_n  = (zr_n == ZW'(ZMAX+1)) || win_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      ones_q <= '0;
      fill_q <= '0;
      zr_q   <= '0;
      pden_q <= 1'b0;
    end else if (bit_en) begin
      sr_q   <= sr_n;
      ones_q <= ones_n;
      fill_q <= fill_n;
      zr_q   <= zr_n;
      pden_q <= pden_n;
    end
  end

  assign pden_o = pden_q;

  // R8: the ones count never exceeds the bits seen
  a_r8_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= fill_q);
  // R7: a rise needs an enabled bit
  a_r7_rise_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pden_q) |-> $past(bit_en));
  // R11: disabled cycles leave the flag alone
  a_r11_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pden_q));
endmodule

// File: rtl/lpm_irq_gen.sv
module lpm_irq_gen #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            both,
  input  logic [NSRC-1:0] src,
  output logic            irq_o
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] hit;
  logic            irq_q, irq_n;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = (src[g] & ~prev_q[g]) | (both & ~src[g] & prev_q[g]);
  end

  always_comb irq_n = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= src;
      irq_q  <= irq_n;
    end
  end

  assign irq_o = irq_q;

  // R9: every strobe follows a change of some status input
  a_r9_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(src != prev_q));
  // R10: a strobe without an onset needs the both-edges option
  a_r10_fall_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && $past((src & ~prev_q) == '0)) |-> $past(both));
endmodule

// File: rtl/los_pd_monitor.sv
module los_pd_monitor #(
  parameter int DW   = 8,
  parameter int SH   = 4,
  parameter int ZMAX = 15,
  parameter int PD_N = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          mark_in,
  input  logic [DW-1:0] det_len,
  input  logic [DW-1:0] rec_marks,
  input  logic          irq_both,
  output logic          los_o,
  output logic          pden_o,
  output logic          irq_o
);
  logic los_w, pden_w;

  lpm_los_detector #(.DW(DW), .SH(SH)) i_los (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark_in(mark_in),
    .det_len(det_len), .rec_marks(rec_marks), .los_o(los_w)
  );

  lpm_density_checker #(.ZMAX(ZMAX), .PD_N(PD_N)) i_pd (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark_in(mark_in),
    .pden_o(pden_w)
  );

  lpm_irq_gen #(.NSRC(2)) i_irq (
    .clk(clk), .rst_n(rst_n), .both(irq_both), .src({pden_w, los_w}),
    .irq_o(irq_o)
  );

  assign los_o  = los_w;
  assign pden_o = pden_w;
endmodule

// File: tb/test_los_pd_monitor.sv
`timescale 1ns/1ps
module test_los_pd_monitor;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic       mark_in;
  logic [7:0] det_len;
  logic [7:0] rec_marks;
  logic       irq_both;
  logic       los_o, pden_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int irq_hi = 0;

  always #5 clk = ~clk;

  los_pd_monitor i_los_pd_monitor (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark_in(mark_in),
    .det_len(det_len), .rec_marks(rec_marks), .irq_both(irq_both),
    .los_o(los_o), .pden_o(pden_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (rst_n && irq_o) irq_hi++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; mark_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    mark_in = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 los", los_o, 0);
    check("R1 pden", pden_o, 0);
    check("R1 irq", irq_o, 0);
  endtask

  // det_len=2 -> span 33 bits
  task automatic t_detect();
    det_len = 8'd2; rec_marks = 8'd3;
    do_reset();
    send_zeros(20);
    send_bit(1'b1);
    send_zeros(10);
    @(negedge clk); mark_in = 1'b1;          // R11: idle cycles carrying a mark
    repeat (20) @(negedge clk);
    mark_in = 1'b0;
    send_zeros(22);
    check("R3 interrupted run, 32 zeros", los_o, 0);
    send_zeros(1);
    check("R2 raise at 33 zeros", los_o, 1);
    check("R11 idle marks ignored", los_o, 1);
  endtask

  task automatic t_recover();
    send_zeros(50);
    check("R4 zeros keep alarm", los_o, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    check("R5 two marks not enough", los_o, 1);
    send_bit(1'b1);
    check("R5 third mark clears", los_o, 0);
  endtask

  task automatic t_expire();
    send_zeros(33);
    check("R2 alarm again", los_o, 1);
    send_bit(1'b1);
    send_zeros(32);
    send_bit(1'b1); send_bit(1'b1);
    check("R6 old span dropped", los_o, 1);
    send_bit(1'b1);
    check("R6 new span clears", los_o, 0);
  endtask

  task automatic t_zero_run();
    det_len = 8'd10;
    do_reset();
    send_bit(1'b1);
    send_zeros(15);
    check("R7 15 zeros ok", pden_o, 0);
    send_zeros(1);
    check("R7 16 zeros flag", pden_o, 1);
    send_bit(1'b1);
    check("R7 mark clears", pden_o, 0);
  endtask

  task automatic t_window();
    int seen_hi = 0;
    det_len = 8'd10;
    do_reset();
    for (int p = 0; p < 192; p++) begin
      send_bit((p % 8 == 0) && (p <= 176));
      if (pden_o) seen_hi = 1;
    end
    check("R8 23 ones in full window", seen_hi, 0);
    send_bit(1'b1);                           // bit 192
    send_zeros(7);                            // bits 193..199
    check("R8 still 23 ones", pden_o, 0);
    send_zeros(1);                            // bit 200
    check("R8 22 ones flags", pden_o, 1);
    send_bit(1'b1);                           // bit 201
    check("R8 slide back to 23", pden_o, 0);
  endtask

  task automatic t_irq();
    det_len = 8'd2; rec_marks = 8'd1; irq_both = 1'b0;
    do_reset();
    irq_hi = 0;
    send_zeros(33);
    send_bit(1'b1);
    repeat (3) @(negedge clk);
    check("R9 rises only, one clock each", irq_hi, 2);
    irq_both = 1'b1;
    send_zeros(33);
    send_bit(1'b1);
    repeat (3) @(negedge clk);
    check("R10 rises plus joint fall", irq_hi, 5);
    check("R10 strobe back low", irq_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; mark_in = 1'b0;
    det_len = 8'hC0; rec_marks = 8'h18; irq_both = 1'b0;
    t_reset();
    t_detect();
    t_recover();
    t_expire();
    t_zero_run();
    t_window();
    t_irq();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule